// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches one asynchronous serial receive line and reports a line break: a low period far longer than any legal character. The raw line is first brought into the system clock domain through a chain of flip-flops. Edges are then found on the synchronised copy. A falling edge zeroes a width counter and starts a measurement. The counter advances once per clock while the line stays low. On the next rising edge the count is captured as the low width.

If the captured width is strictly above the `BREAK_TICKS` parameter (default 8800), a pulse one clock wide is issued. It comes three clock edges after the raw line returns high, so a downstream frame receiver can be armed before the first start bit of the next frame. The `enable` input gates only the pulse. Measurements and width captures go on whether it is high or low.

If a low period runs past the largest value the counter can hold, the counter saturates and an overflow state is entered. The rising edge that ends that period then discards the measurement instead of comparing it. The discard also clears the overflow state.

The controller has three states. `ST_HIGH` is the idle state with the line high. `ST_LOW` is measuring a low period. `ST_SAT` means the counter has saturated. Its transitions are:
- fall: `ST_HIGH` to `ST_LOW`, counter zeroed.
- count: `ST_LOW` to `ST_LOW`, counter incremented.
- capture: `ST_LOW` to `ST_HIGH` on a rising edge.
- saturate: `ST_LOW` to `ST_SAT` when the counter is full and the line is still low.
- hold: `ST_SAT` to `ST_SAT`.
- discard: `ST_SAT` to `ST_HIGH` on a rising edge.

Top module: `lbd_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `brk_pulse` is 0 and `low_width` is 0.
- R2: After the raw line has been held low for N consecutive clock cycles and then returns high, `low_width` equals N-1, provided N-1 does not exceed the counter maximum. The counter is zeroed at the falling edge and captured at the rising edge.
- R3: A measurement with captured width strictly greater than `BREAK_TICKS` produces exactly one `brk_pulse` cycle. A width equal to or below `BREAK_TICKS` produces none, and no pulse appears while the line is low.
- R4: The break pulse is high in the clock cycle that follows the third rising clock edge after the raw line returns high.
- R5: While `enable` is 0 no break pulse is produced. `low_width` is still updated.
- R6: If the line stays low past the counter maximum (N-1 > 2^CNT_W - 1), the counter saturates. The measurement is discarded: `low_width` keeps its previous value and no pulse is issued.
- R7: The discard clears the overflow condition, so the next low period is measured and tested normally.
- R8: A low period whose width exactly equals the counter maximum (N-1 = 2^CNT_W - 1) is a valid measurement. It is captured and tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_raw | input | 1 | Asynchronous serial receive line, idle high |
| enable | input | 1 | Allows the break pulse when high |
| brk_pulse | output | 1 | One-cycle line break indication |
| low_width | output | CNT_W | Width of the last accepted low period, in clock ticks |

## Verification
A controller stuck in `ST_SAT` or `ST_LOW` shows up at the first rising edge that follows. The expected width update does not appear, or a stale width is compared, within three cycles of the line going high. A counter that wraps instead of saturating shows up as a small width or a stray pulse after a very long low period. Such periods are driven on purpose just beyond the counter limit. An off-by-one in the compare or the capture changes the pulse decision at widths `BREAK_TICKS` and `BREAK_TICKS`+1, and the width value on every measurement. Both show in the same window after each rising edge.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
    typedef enum logic [1:0] {
        ST_HIGH = 2'd0,
        ST_LOW  = 2'd1,
        ST_SAT  = 2'd2
    } lbd_state_e;
endpackage

// File: rtl/lbd_sync.sv
module lbd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic line,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Flops reset to the idle-high level of the line.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign line = chain[STAGES-1];
    assign fall = prev & ~line;
    assign rise = ~prev & line;
endmodule

// File: rtl/lbd_width_cnt.sv
module lbd_width_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (clear)          count <= '0;
        else if (inc && !at_max) count <= count + 1'b1;
    end

    assign at_max = (count == CNT_MAX);
endmodule

// File: rtl/lbd_fsm.sv
module lbd_fsm
    import lbd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BREAK_TICKS = 8800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             rise,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    input  logic             at_max,
    output logic             cnt_clear,
    output logic             cnt_inc,
    output logic             ovf_flag,
    output logic             brk_pulse,
    output logic [CNT_W-1:0] low_width
);
    localparam logic [CNT_W:0] THRESH = (CNT_W+1)'(BREAK_TICKS);

    lbd_state_e state, state_nx;
    logic       capture;
    logic       over_thresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HIGH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_HIGH: begin
                if (fall) begin
                    cnt_clear = 1'b1;
                    state_nx  = ST_LOW;
                end
            end
            ST_LOW: begin
                if (rise) begin
                    capture  = 1'b1;
                    state_nx = ST_HIGH;
                end else if (at_max) begin
                    state_nx = ST_SAT;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_SAT: begin
                if (rise) state_nx = ST_HIGH;
            end
            default: state_nx = ST_HIGH;
        endcase
    end

    assign ovf_flag    = (state == ST_SAT);
    assign over_thresh = ({1'b0, count} > THRESH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_pulse <= 1'b0;
            low_width <= '0;
        end else begin
            brk_pulse <= capture && enable && over_thresh;
            if (capture) low_width <= count;
        end
    end
endmodule

// File: rtl/lbd_top.sv
module lbd_top #(
    parameter int CNT_W       = 16,
    parameter int BREAK_TICKS = 8800,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_raw,
    input  logic             enable,
    output logic             brk_pulse,
    output logic [CNT_W-1:0] low_width
);
    logic             line_sync;
    logic             line_fall;
    logic             line_rise;
    logic             cnt_clear;
    logic             cnt_inc;
    logic             cnt_at_max;
    logic             ovf_flag;
    logic [CNT_W-1:0] width_cnt;

    lbd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (rx_raw),
        .line (line_sync),
        .fall (line_fall),
        .rise (line_rise)
    );

    lbd_width_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .count (width_cnt),
        .at_max(cnt_at_max)
    );

    lbd_fsm #(.CNT_W(CNT_W), .BREAK_TICKS(BREAK_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall     (line_fall),
        .rise     (line_rise),
        .enable   (enable),
        .count    (width_cnt),
        .at_max   (cnt_at_max),
        .cnt_clear(cnt_clear),
        .cnt_inc  (cnt_inc),
        .ovf_flag (ovf_flag),
        .brk_pulse(brk_pulse),
        .low_width(low_width)
    );
endmodule

// File: rtl/lbd_checker.sv
module lbd_checker #(
    parameter int CNT_W       = 16,
    parameter int BREAK_TICKS = 8800
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             brk_pulse,
    input logic [CNT_W-1:0] low_width,
    input logic             rise,
    input logic             ovf,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W:0] THR = (CNT_W+1)'(BREAK_TICKS);

    // R3: pulse lasts one cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    // R3: a pulse always goes with a captured width above threshold
    a_r3_above_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> ({1'b0, low_width} > THR));

    // R5: pulse only when enable was high in the deciding cycle
    a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(enable));

    // R2: width changes only after a rising edge
    a_r2_width_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(low_width) |-> $past(rise));

    // R6: saturated counter sits at its maximum
    a_r6_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == {CNT_W{1'b1}}));

    // R6, R7: a rising edge in overflow discards and clears
    a_r6_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && rise) |=> ($stable(low_width) && !brk_pulse && !ovf));
endmodule

bind lbd_top lbd_checker #(.CNT_W(CNT_W), .BREAK_TICKS(BREAK_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .brk_pulse(brk_pulse),
    .low_width(low_width),
    .rise     (line_rise),
    .ovf      (ovf_flag),
    .count    (width_cnt)
);

// File: tb/tb_lbd_top.sv
module tb_lbd_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int THR        = 300;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_raw = 1'b1;
    logic             enable = 1'b1;
    logic             brk_pulse;
    logic [CNT_W-1:0] low_width;

    int checks = 0;
    int errors = 0;
    int model_width = 0;
    bit finished = 1'b0;

    lbd_top #(.CNT_W(CNT_W), .BREAK_TICKS(THR), .SYNC_STAGES(2)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_raw   (rx_raw),
        .enable   (enable),
        .brk_pulse(brk_pulse),
        .low_width(low_width)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit exp_valid(int n);
        return (n - 1) <= CMAX;
    endfunction

    function automatic bit exp_pulse(int n, bit en);
        return exp_valid(n) && en && ((n - 1) > THR);
    endfunction

    task automatic check(bit ok, string req, int got, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    // Hold the line low for n cycles, release, and observe the outcome.
    task automatic low_pulse(int n, bit en);
        int stray = 0;
        int pulses = 0;
        int pos = 0;
        bit ep;
        enable = en;
        rx_raw = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (brk_pulse && i > 2) stray++;
        end
        rx_raw = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (brk_pulse) begin
                pulses++;
                pos = i;
            end
        end
        ep = exp_pulse(n, en);
        if (exp_valid(n)) model_width = n - 1;
        // R3: no pulse while the line is low
        check(stray == 0, "R3 low-phase", stray, 0);
        // R3 / R5 / R6: number of pulses
        check(pulses == (ep ? 1 : 0), ep ? "R3 pulse" : "R5/R6 no pulse", pulses, ep ? 1 : 0);
        // R4: position of the pulse
        if (ep) check(pos == 3, "R4 latency", pos, 3);
        // R2 / R6 / R8: captured width
        check(int'(low_width) == model_width, exp_valid(n) ? "R2 width" : "R6 width kept",
              int'(low_width), model_width);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5a17));
        repeat (3) @(negedge clk);
        // R1: reset values while reset is asserted
        check(brk_pulse == 1'b0, "R1 pulse in reset", int'(brk_pulse), 0);
        check(low_width == '0, "R1 width in reset", int'(low_width), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(brk_pulse == 1'b0 && low_width == '0, "R1 after reset",
              int'(low_width) + int'(brk_pulse), 0);
        repeat (4) @(negedge clk);

        low_pulse(1, 1'b1);          // R2 shortest glitch, width 0
        low_pulse(THR + 1, 1'b1);    // R3 width == threshold, no pulse
        low_pulse(THR + 2, 1'b1);    // R3 width == threshold+1, pulse
        low_pulse(500, 1'b0);        // R5 enable low
        low_pulse(CMAX + 1, 1'b1);   // R8 width exactly at counter max
        low_pulse(CMAX + 2, 1'b1);   // R6 one past max, discarded
        low_pulse(CMAX + 40, 1'b1);  // R6 long overflow, discarded
        low_pulse(50, 1'b1);         // R7 normal after discard
        low_pulse(THR + 20, 1'b1);   // R7 break after discard

        for (int k = 0; k < 40; k++) begin
            int n;
            bit en;
            n  = 1 + int'($urandom % (CMAX + 80));
            en = ($urandom % 5) != 0;
            low_pulse(n, en);
            repeat (int'($urandom % 4)) @(negedge clk);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule